// File: doc/BRIEF.md
# Storage Attribute Access Controller

This block sits between a load/store pipeline and the memory port. Each request carries an operation code, the four page attribute bits of its page (write-through, caching-inhibited, coherence-required, guarded), a cache hit flag and a speculative flag. The block picks one of three routes for the request: a read from the cache, a write to the cache, or a memory access. It may also raise an exception instead, and it passes the coherence bit to the memory request as a transfer attribute.

The write-through bit never changes routing. Every store goes to memory, and a store also updates the cache when it hits. Block-zero and reservation operations fault when their page is write-through or caching-inhibited. A guarded access that would reach memory waits until it is no longer speculative, or until a flush discards it. Only one memory request is in flight at a time.

Top module: `sa_attr_ctrl`

## Requirements
- R1: A store (op code 1) always starts a memory write (`mem_req`=1, `mem_we`=1), whatever `req_wt` says. It also pulses `cache_wr_en` only when `req_hit`=1 and `req_ci`=0.
- R2: A block-zero (op code 3) with `req_wt`=1 or `req_ci`=1 pulses `exc_align` and performs no access. Without those bits it pulses `cache_wr_en` on a hit, and on a miss it starts a memory write.
- R3: A load-reserve (op 4) or store-conditional (op 5) with `req_wt`=1 or `req_ci`=1 pulses `exc_storage` and performs no access. Without those bits, load-reserve behaves as a load and store-conditional behaves as a store.
- R4: A load (op 0) or instruction fetch (op 2) with `req_ci`=1 starts a memory read (`mem_we`=0) and never pulses `cache_rd_en`, even when it hits.
- R5: A load or fetch with `req_ci`=0 pulses `cache_rd_en` on a hit with no memory access. On a miss it starts a memory read.
- R6: `mem_coh` carries the `req_coh` value of the request that started the memory access. `req_coh` changes no route and no exception.
- R7: A request with `req_grd`=1 and `req_spec`=1 that would start a memory access holds `req_ready` low and makes no access until `req_spec` clears. A guarded request that would not reach memory (a cache hit or a fault) does not stall.
- R8: A request presented with `req_flush`=1 while the block is idle is taken (`req_ready`=1) and discarded. It produces no enable, no exception and no memory access.
- R9: Cache-management operations (op 6; op 7 is treated the same) are accepted with `req_ci`=0 or 1. They raise no exception and perform no access.
- R10: Each exception is high for exactly one cycle, the cycle after the clock edge that accepts the faulting request. A faulting request asserts no cache or memory enable.
- R11: While `mem_req` is high, `req_ready` is low. `mem_req`, `mem_we` and `mem_coh` hold until the edge that samples `mem_ack`=1, and `req_ready` returns in the next cycle.
- R12: After reset all enables and exceptions are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_op | input | 3 | Operation code (0 load, 1 store, 2 fetch, 3 block-zero, 4 load-reserve, 5 store-conditional, 6/7 cache management) |
| req_wt | input | 1 | Page write-through attribute |
| req_ci | input | 1 | Page caching-inhibited attribute |
| req_coh | input | 1 | Page coherence-required attribute |
| req_grd | input | 1 | Page guarded attribute |
| req_hit | input | 1 | Line present in the cache |
| req_spec | input | 1 | Request is still speculative |
| req_flush | input | 1 | Discard the presented request |
| mem_ack | input | 1 | Memory accepted the outstanding request |
| cache_rd_en | output | 1 | One-cycle pulse: serve from the cache |
| cache_wr_en | output | 1 | One-cycle pulse: write the cache |
| mem_req | output | 1 | Memory access outstanding |
| mem_we | output | 1 | Outstanding access is a write |
| mem_coh | output | 1 | Coherence transfer attribute of the access |
| exc_align | output | 1 | Alignment exception pulse |
| exc_storage | output | 1 | Data storage exception pulse |

## Verification
The bench covers stores to write-through pages. A design that honours the bit would skip the memory write. It also covers loads that hit on caching-inhibited pages, which a faulty design would serve from the cache, and faulting block-zero and reservation operations, which a faulty design would let leak an enable. It holds a guarded miss speculative for several cycles and then flushes one. An early memory request or a late one shows up on `mem_req` and `req_ready`. Finally it presents a new request while a memory access is in flight, so a second access issued before the acknowledge is seen at once.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SA_OP_LOAD   = 3'd0,
    SA_OP_STORE  = 3'd1,
    SA_OP_FETCH  = 3'd2,
    SA_OP_BZERO  = 3'd3,
    SA_OP_LDRSV  = 3'd4,
    SA_OP_STCOND = 3'd5,
    SA_OP_CMGMT  = 3'd6,
    SA_OP_CMGMT2 = 3'd7
  } sa_op_e;

  typedef struct packed {
    logic cache_rd;
    logic cache_wr;
    logic mem_acc;
    logic mem_wr;
    logic exc_align;
    logic exc_storage;
  } sa_route_t;

  function automatic sa_route_t sa_classify(sa_op_e op, logic wt, logic ci, logic hit);
    sa_route_t r;
    logic      bad_page;
    r        = '0;
    bad_page = wt | ci;
    case (op)
      SA_OP_LOAD, SA_OP_FETCH: begin
        if (!ci && hit) r.cache_rd = 1'b1;
        else            r.mem_acc  = 1'b1;
      end
      SA_OP_STORE: begin
        r.mem_acc  = 1'b1;
        r.mem_wr   = 1'b1;
        r.cache_wr = hit & ~ci;
      end
      SA_OP_BZERO: begin
        if (bad_page) r.exc_align = 1'b1;
        else if (hit) r.cache_wr  = 1'b1;
        else begin
          r.mem_acc = 1'b1;
          r.mem_wr  = 1'b1;
        end
      end
      SA_OP_LDRSV: begin
        if (bad_page) r.exc_storage = 1'b1;
        else if (hit) r.cache_rd    = 1'b1;
        else          r.mem_acc     = 1'b1;
      end
      SA_OP_STCOND: begin
        if (bad_page) r.exc_storage = 1'b1;
        else begin
          r.mem_acc  = 1'b1;
          r.mem_wr   = 1'b1;
          r.cache_wr = hit;
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sa_route_decode.sv
module sa_route_decode
  import sa_pkg::*;
(
  input  logic [OP_W-1:0] op_raw,
  input  logic            wt,
  input  logic            ci,
  input  logic            hit,
  output sa_route_t       route,
  output logic            need_mem
);
  always_comb begin
    route    = sa_classify(sa_op_e'(op_raw), wt, ci, hit);
    need_mem = route.mem_acc;
  end
endmodule

// File: rtl/sa_guard_gate.sv
module sa_guard_gate (
  input  logic busy,
  input  logic req_valid,
  input  logic grd,
  input  logic spec,
  input  logic flush,
  input  logic need_mem,
  output logic stall,
  output logic ready,
  output logic take
);
  always_comb begin
    stall = req_valid & grd & spec & need_mem & ~flush;
    ready = ~busy & ~stall;
    take  = req_valid & ready & ~flush;
  end
endmodule

// File: rtl/sa_mem_tracker.sv
module sa_mem_tracker
  import sa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  sa_route_t route,
  input  logic      coh,
  input  logic      mem_ack,
  output logic      busy,
  output logic      cache_rd_en,
  output logic      cache_wr_en,
  output logic      mem_req,
  output logic      mem_we,
  output logic      mem_coh,
  output logic      exc_align,
  output logic      exc_storage
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_rd_en <= 1'b0;
      cache_wr_en <= 1'b0;
      exc_align   <= 1'b0;
      exc_storage <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_coh     <= 1'b0;
    end else begin
      cache_rd_en <= take & route.cache_rd;
      cache_wr_en <= take & route.cache_wr;
      exc_align   <= take & route.exc_align;
      exc_storage <= take & route.exc_storage;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          mem_coh <= 1'b0;
        end
      end else if (take && route.mem_acc) begin
        mem_req <= 1'b1;
        mem_we  <= route.mem_wr;
        mem_coh <= coh;
      end
    end
  end

  assign busy = mem_req;
endmodule

// File: rtl/sa_attr_ctrl.sv
module sa_attr_ctrl
  import sa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OP_W-1:0] req_op,
  input  logic            req_wt,
  input  logic            req_ci,
  input  logic            req_coh,
  input  logic            req_grd,
  input  logic            req_hit,
  input  logic            req_spec,
  input  logic            req_flush,
  input  logic            mem_ack,
  output logic            cache_rd_en,
  output logic            cache_wr_en,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_coh,
  output logic            exc_align,
  output logic            exc_storage
);
  sa_route_t route;
  logic      need_mem;
  logic      busy;
  logic      stall;
  logic      take;

  sa_route_decode u_decode (
    .op_raw   (req_op),
    .wt       (req_wt),
    .ci       (req_ci),
    .hit      (req_hit),
    .route    (route),
    .need_mem (need_mem)
  );

  sa_guard_gate u_gate (
    .busy      (busy),
    .req_valid (req_valid),
    .grd       (req_grd),
    .spec      (req_spec),
    .flush     (req_flush),
    .need_mem  (need_mem),
    .stall     (stall),
    .ready     (req_ready),
    .take      (take)
  );

  sa_mem_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .route       (route),
    .coh         (req_coh),
    .mem_ack     (mem_ack),
    .busy        (busy),
    .cache_rd_en (cache_rd_en),
    .cache_wr_en (cache_wr_en),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_coh     (mem_coh),
    .exc_align   (exc_align),
    .exc_storage (exc_storage)
  );
endmodule

// File: rtl/sa_attr_ctrl_chk.sv
module sa_attr_ctrl_chk
  import sa_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [OP_W-1:0] req_op,
  input logic            req_wt,
  input logic            req_ci,
  input logic            req_coh,
  input logic            req_grd,
  input logic            req_spec,
  input logic            req_flush,
  input logic            mem_ack,
  input logic            take,
  input logic            cache_rd_en,
  input logic            cache_wr_en,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_coh,
  input logic            exc_align,
  input logic            exc_storage
);
  logic is_store, is_bzero, is_rsv, is_rd;
  assign is_store = (req_op == SA_OP_STORE);
  assign is_bzero = (req_op == SA_OP_BZERO);
  assign is_rsv   = (req_op == SA_OP_LDRSV) || (req_op == SA_OP_STCOND);
  assign is_rd    = (req_op == SA_OP_LOAD) || (req_op == SA_OP_FETCH);

  AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_store) |=> (mem_req && mem_we)); // R1
  AST_BZERO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_bzero && (req_wt || req_ci)) |=> (exc_align && !mem_req)); // R2
  AST_RSV_STORAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_rsv && (req_wt || req_ci)) |=> (exc_storage && !mem_req)); // R3
  AST_CI_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_rd && req_ci) |=> (mem_req && !mem_we && !cache_rd_en)); // R4
  AST_COH_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_coh == $past(req_coh))); // R6
  AST_GUARD_NONSPEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !$past(req_grd && req_spec)); // R7
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_flush) |=> (!$rose(mem_req) && !cache_rd_en && !cache_wr_en
                                  && !exc_align && !exc_storage)); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_align || exc_storage) |-> !(cache_rd_en || cache_wr_en || mem_req)); // R10
  AST_EXC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_align || exc_storage) |-> $past(req_valid && req_ready && !req_flush)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R11
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_coh))); // R11
endmodule

bind sa_attr_ctrl sa_attr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_wt      (req_wt),
  .req_ci      (req_ci),
  .req_coh     (req_coh),
  .req_grd     (req_grd),
  .req_spec    (req_spec),
  .req_flush   (req_flush),
  .mem_ack     (mem_ack),
  .take        (take),
  .cache_rd_en (cache_rd_en),
  .cache_wr_en (cache_wr_en),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_coh     (mem_coh),
  .exc_align   (exc_align),
  .exc_storage (exc_storage)
);

// File: tb/sa_attr_ctrl_tb_top.sv
`timescale 1ns/1ps
module sa_attr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic req_wt = 0, req_ci = 0, req_coh = 0, req_grd = 0, req_hit = 0, req_spec = 0, req_flush = 0;
  logic mem_ack = 1'b0;
  logic cache_rd_en, cache_wr_en, mem_req, mem_we, mem_coh, exc_align, exc_storage;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sa_attr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wt(req_wt), .req_ci(req_ci), .req_coh(req_coh),
    .req_grd(req_grd), .req_hit(req_hit), .req_spec(req_spec), .req_flush(req_flush),
    .mem_ack(mem_ack), .cache_rd_en(cache_rd_en), .cache_wr_en(cache_wr_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_coh(mem_coh),
    .exc_align(exc_align), .exc_storage(exc_storage)
  );

  // {op[3], wt, ci, coh, grd, hit, exp: crd, cwr, mem, mwe, align, storage}
  localparam int NV = 22;
  localparam logic [13:0] VECS [NV] = '{
    {3'd0, 5'b00001, 6'b100000},
    {3'd0, 5'b00000, 6'b001000},
    {3'd0, 5'b01001, 6'b001000},
    {3'd1, 5'b00001, 6'b011100},
    {3'd1, 5'b00000, 6'b001100},
    {3'd1, 5'b10001, 6'b011100},
    {3'd1, 5'b01001, 6'b001100},
    {3'd2, 5'b00001, 6'b100000},
    {3'd2, 5'b01001, 6'b001000},
    {3'd3, 5'b10001, 6'b000010},
    {3'd3, 5'b01000, 6'b000010},
    {3'd3, 5'b00001, 6'b010000},
    {3'd3, 5'b00000, 6'b001100},
    {3'd4, 5'b10001, 6'b000001},
    {3'd5, 5'b01000, 6'b000001},
    {3'd4, 5'b00001, 6'b100000},
    {3'd5, 5'b00000, 6'b001100},
    {3'd6, 5'b01001, 6'b000000},
    {3'd6, 5'b00000, 6'b000000},
    {3'd0, 5'b00100, 6'b001000},
    {3'd3, 5'b10110, 6'b000010},
    {3'd7, 5'b01000, 6'b000000}
  };

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] op, logic ci, logic coh);
    string t;
    case (op)
      3'd0, 3'd2: t = ci ? "R4" : "R5";
      3'd1: t = "R1";
      3'd3: t = "R2";
      3'd4, 3'd5: t = "R3";
      default: t = "R9";
    endcase
    if (coh) t = {t, "/R6"};
    return t;
  endfunction

  task automatic drive(logic [2:0] op, logic wt, logic ci, logic coh, logic grd,
                       logic hit, logic spec, logic fl);
    req_valid = 1'b1; req_op = op; req_wt = wt; req_ci = ci; req_coh = coh;
    req_grd = grd; req_hit = hit; req_spec = spec; req_flush = fl;
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_flush = 1'b0; req_spec = 1'b0; req_grd = 1'b0;
  endtask

  function automatic logic [5:0] outs();
    return {cache_rd_en, cache_wr_en, mem_req, mem_we, exc_align, exc_storage};
  endfunction

  task automatic ack_mem(string tag);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    check(tag, "mem_req cleared after ack", mem_req, 0);
    check("R11", "ready after ack", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    // R12 reset state
    check("R12", "outputs after reset", {2'b0, outs()}, 8'h00);
    check("R12", "ready after reset", req_ready, 1);
    check("R12", "mem_coh after reset", mem_coh, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [13:0] v;
      string t;
      v = VECS[k];
      t = tag_of(v[13:11], v[9], v[8]);
      @(negedge clk);
      drive(v[13:11], v[10], v[9], v[8], v[7], v[6], 1'b0, 1'b0);
      #0.5;
      check(t, "ready before accept", req_ready, 1);
      @(negedge clk);
      idle_inputs();
      check(t, $sformatf("vector %0d outputs", k), {2'b0, outs()}, {2'b0, v[5:0]});
      if (v[3]) begin
        check(t, "coherence attribute", mem_coh, v[8]);
        ack_mem(t);
      end else begin
        @(negedge clk);
        check("R10", "pulses end after one cycle", {2'b0, outs()}, 8'h00);
      end
    end

    // R11: busy blocks new request, fields held until ack
    @(negedge clk);
    drive(3'd0, 0, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    drive(3'd1, 0, 0, 0, 0, 1, 0, 0);
    #0.5;
    check("R11", "ready low while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    check("R11", "held mem_req/we/coh", {5'b0, mem_req, mem_we, mem_coh}, 8'h05);
    check("R11", "no cache write while blocked", cache_wr_en, 0);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R11", "ready back after ack", req_ready, 1);
    @(negedge clk);
    idle_inputs();
    check("R11", "queued store starts", {2'b0, outs()}, 8'h1C);
    ack_mem("R11");

    // R7: guarded speculative miss stalls
    @(negedge clk);
    drive(3'd0, 0, 0, 0, 1, 0, 1, 0);
    #0.5;
    check("R7", "ready low while speculative", req_ready, 0);
    repeat (4) @(negedge clk);
    check("R7", "no access while speculative", mem_req, 0);
    req_spec = 1'b0;
    #0.5;
    check("R7", "ready once non-speculative", req_ready, 1);
    @(negedge clk);
    idle_inputs();
    check("R7", "memory read after spec clears", {2'b0, outs()}, 8'h08);
    ack_mem("R7");

    // R7: guarded speculative cache hit and fault do not stall
    @(negedge clk);
    drive(3'd0, 0, 0, 0, 1, 1, 1, 0);
    #0.5;
    check("R7", "guarded hit not stalled", req_ready, 1);
    @(negedge clk);
    drive(3'd3, 1, 0, 0, 1, 1, 1, 0);
    check("R7", "guarded hit from cache", {2'b0, outs()}, 8'h20);
    #0.5;
    check("R7", "guarded fault not stalled", req_ready, 1);
    @(negedge clk);
    idle_inputs();
    check("R10", "guarded block-zero faults", {2'b0, outs()}, 8'h02);

    // R8: flush cancels a stalled guarded request
    @(negedge clk);
    drive(3'd1, 0, 0, 0, 1, 0, 1, 0);
    repeat (2) @(negedge clk);
    req_flush = 1'b1;
    #0.5;
    check("R8", "flush takes request", req_ready, 1);
    @(negedge clk);
    idle_inputs();
    check("R8", "flushed request no effect", {2'b0, outs()}, 8'h00);
    @(negedge clk);
    check("R8", "still no access", {2'b0, outs()}, 8'h00);

    // R8: flush discards an ordinary store
    drive(3'd1, 0, 0, 0, 0, 1, 0, 1);
    @(negedge clk);
    idle_inputs();
    check("R8", "flushed store no write", {2'b0, outs()}, 8'h00);
    check("R12", "ready idle after flush", req_ready, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule